// File: doc/BRIEF.md
# Two-Lane Link with Adaptive Packet Slicing

This block holds both ends of a two-lane link that falls back to redundant transmission when one lane turns unreliable. Each packet is `2*HALF_W` bits wide. In split mode the transmitter cuts a packet into a low half and a high half and launches both halves in the same cycle, one on each lane. Every lane beat carries a two-bit header and a CRC-8, so the receiver can check each lane on its own.

The receiver counts failed lane beats over a window of `WIN` delivered packets. When a window closes with at least `ENTER_TH` failures, the transmitter changes to duplicate mode. In that mode it sends the full packet on both lanes over two beats, which halves the packet rate. The receiver keeps checking both lanes and delivers whichever copy arrived intact. A window that closes with at most `EXIT_TH` failures returns the link to split mode. A count between the two thresholds keeps the current mode. A mode change never splits a packet.

The transmit lanes leave the block on `tx_lane*` and come back in on `rx_lane*`. In the system they pass through the physical link, and on the bench they pass through an error injector. Packets enter on a valid/ready stream. They leave as a valid-qualified stream that has no backpressure, because a serial lane cannot be stalled.

Top module: `slice_link`

## Requirements
- R1: A lane beat is `FW = HALF_W+10` bits. Bit FW-1 is the mode (0 split, 1 duplicate), bit FW-2 is the part (0 low half, 1 high half), bits FW-3..8 carry a half packet, and bits 7..0 carry a CRC-8. The CRC uses polynomial 0x07 with initial value 0 and is taken MSB first over bits FW-1..8.
- R2: In split mode an accepted packet appears on the lanes in the next cycle as one beat. Lane 0 carries the low half with part 0, and lane 1 carries the high half with part 1. `in_ready` stays high, so one packet can be taken every cycle.
- R3: In duplicate mode an accepted packet takes two consecutive beats, the low half and then the high half, with identical frames on both lanes. `in_ready` is low while the first beat is on the lanes.
- R4: A split beat received at an edge gives `out_valid` after that edge, with data reassembled as {lane 1 half, lane 0 half}. `out_err` is set when either lane fails its CRC.
- R5: A duplicate packet is delivered after its second beat. The lane 0 copy is used if both of its beats passed, otherwise the lane 1 copy. `out_err` is set only if each copy has at least one failed beat.
- R6: Each failing lane beat adds one to an error count. After every `WIN` delivered packets the count is compared: at least `ENTER_TH` selects duplicate mode, at most `EXIT_TH` selects split mode, and any value in between keeps the mode. The count then clears. `dup_mode` changes only in a cycle where `out_valid` rises.
- R7: The mode is sampled when a packet is accepted, and all beats of that packet carry it. A packet accepted after `dup_mode` changes uses the new mode.
- R8: After reset, `dup_mode`, `tx_lane_vld` and `out_valid` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet taken this cycle when valid |
| in_data | input | 2*HALF_W | Packet to send |
| tx_lane_vld | output | 1 | Lane beats valid |
| tx_lane0 | output | FW | Lane 0 transmit beat |
| tx_lane1 | output | FW | Lane 1 transmit beat |
| rx_lane_vld | input | 1 | Received lane beats valid |
| rx_lane0 | input | FW | Lane 0 received beat |
| rx_lane1 | input | FW | Lane 1 received beat |
| out_valid | output | 1 | Packet delivered |
| out_data | output | 2*HALF_W | Delivered packet |
| out_err | output | 1 | Delivered packet failed its checks |
| dup_mode | output | 1 | Current transmit mode, 1 for duplicate |

## Verification
The hardest cases to reach from the ports are the two duplicate-mode recoveries. In one, each copy is damaged but in a different beat, so the packet still fails although no single beat lost both lanes. In the other, a copy is lost on one lane while the other lane saves it. To get there, the link first has to be pushed into duplicate mode by a window that holds enough lane failures. The stimulus therefore runs directed windows. One window has a failure count between the two thresholds and must keep the mode. One has enough failures to enter duplicate mode. One runs in duplicate mode and damages chosen beats of each copy. A clean window then brings the link back to split mode. A seeded random phase follows, which varies the data and the corruption pattern.

// File: rtl/slk_pkg.sv
// Shared constants for the sliced two-lane link.
// Assumes: lane beat layout {mode, part, half, crc8}, MSB first.
package slk_pkg;
    localparam logic [7:0] CRC_POLY = 8'h07;
    typedef enum logic {MODE_SPLIT = 1'b0, MODE_DUP = 1'b1} link_mode_e;
endpackage

// File: rtl/slk_crc8.sv
// Combinational CRC-8 over a DW-bit word, MSB first, zero initial value.
// Assumes: DW >= 1.
module slk_crc8 #(
    parameter int DW = 18
) (
    input  logic [DW-1:0] din,
    output logic [7:0]    crc
);
    // Bitwise shift of the LFSR across the word
    always_comb begin
        crc = 8'h00;
        for (int i = DW - 1; i >= 0; i--) begin
            crc = {crc[6:0], 1'b0} ^ (((crc[7] ^ din[i]) == 1'b1) ? slk_pkg::CRC_POLY : 8'h00);
        end
    end
endmodule

// File: rtl/slk_tx.sv
// Transmitter: frames packets onto two lanes, split or duplicated.
// Assumes: dup_req is sampled only when a packet is accepted; a duplicate
// packet occupies two consecutive beats and blocks input on the second.
module slk_tx #(
    parameter int HALF_W = 16,
    localparam int PW = HALF_W + 2,
    localparam int FW = PW + 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2*HALF_W-1:0]   in_data,
    input  logic                  dup_req,
    output logic                  lane_vld,
    output logic [1:0][FW-1:0]    lanes
);
    import slk_pkg::*;

    logic              busy2;
    logic [HALF_W-1:0] hi_hold;
    logic              accept;
    logic [1:0][PW-1:0] pay;
    logic [1:0][7:0]    crc;

    assign in_ready = !busy2;
    assign accept   = in_valid && !busy2;

    // Pick the header and half carried by each lane this cycle
    always_comb begin
        if (busy2) begin
            pay[0] = {MODE_DUP, 1'b1, hi_hold};
            pay[1] = {MODE_DUP, 1'b1, hi_hold};
        end else if (dup_req) begin
            pay[0] = {MODE_DUP, 1'b0, in_data[HALF_W-1:0]};
            pay[1] = {MODE_DUP, 1'b0, in_data[HALF_W-1:0]};
        end else begin
            pay[0] = {MODE_SPLIT, 1'b0, in_data[HALF_W-1:0]};
            pay[1] = {MODE_SPLIT, 1'b1, in_data[2*HALF_W-1:HALF_W]};
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_crc
        slk_crc8 #(.DW(PW)) i_crc (.din(pay[g]), .crc(crc[g]));
    end

    // Launch beats and track the pending second duplicate beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_vld <= 1'b0;
            lanes    <= '0;
            busy2    <= 1'b0;
            hi_hold  <= '0;
        end else begin
            lane_vld <= accept || busy2;
            if (accept || busy2) begin
                lanes[0] <= {pay[0], crc[0]};
                lanes[1] <= {pay[1], crc[1]};
            end
            if (accept && dup_req) begin
                busy2   <= 1'b1;
                hi_hold <= in_data[2*HALF_W-1:HALF_W];
            end else if (busy2) begin
                busy2 <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slk_rx.sv
// Receiver: checks each lane's CRC, reassembles split packets, and picks a
// surviving copy of duplicate packets.
// Assumes: the header is read from a lane that passed its CRC; a beat whose
// lanes both fail with no pending duplicate is taken as a split beat.
module slk_rx #(
    parameter int HALF_W = 16,
    localparam int PW = HALF_W + 2,
    localparam int FW = PW + 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lane_vld,
    input  logic [1:0][FW-1:0]    lanes,
    output logic                  out_valid,
    output logic [2*HALF_W-1:0]   out_data,
    output logic                  out_err,
    output logic [1:0]            lane_bad,
    output logic                  pkt_done
);
    logic [1:0][7:0]        crc;
    logic [1:0]             ok;
    logic [1:0]             good;
    logic [1:0]             hdr;
    logic                   pend;
    logic                   start_dup;
    logic [1:0][HALF_W-1:0] lo_keep;
    logic [1:0]             lo_ok;

    for (genvar g = 0; g < 2; g++) begin : g_chk
        slk_crc8 #(.DW(PW)) i_crc (.din(lanes[g][FW-1:8]), .crc(crc[g]));
        assign ok[g]   = (crc[g] == lanes[g][7:0]);
        assign good[g] = lo_ok[g] && ok[g];
    end

    // Header from the first lane that passed its check
    always_comb begin
        if (ok[0])      hdr = lanes[0][FW-1:FW-2];
        else if (ok[1]) hdr = lanes[1][FW-1:FW-2];
        else            hdr = 2'b00;
    end

    assign start_dup = !pend && (hdr == 2'b10);
    assign pkt_done  = lane_vld && !start_dup;
    assign lane_bad  = {2{lane_vld}} & ~ok;

    // Deliver packets and hold the first duplicate beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
            pend      <= 1'b0;
            lo_keep   <= '0;
            lo_ok     <= '0;
        end else begin
            out_valid <= pkt_done;
            if (lane_vld) begin
                if (pend) begin
                    pend    <= 1'b0;
                    out_err <= !good[0] && !good[1];
                    if (good[0] || !good[1]) out_data <= {lanes[0][FW-3:8], lo_keep[0]};
                    else                     out_data <= {lanes[1][FW-3:8], lo_keep[1]};
                end else if (start_dup) begin
                    pend       <= 1'b1;
                    lo_keep[0] <= lanes[0][FW-3:8];
                    lo_keep[1] <= lanes[1][FW-3:8];
                    lo_ok      <= ok;
                end else begin
                    out_err  <= !(ok[0] && ok[1]);
                    out_data <= {lanes[1][FW-3:8], lanes[0][FW-3:8]};
                end
            end
        end
    end
endmodule

// File: rtl/slk_err_window.sv
// Error-rate monitor: counts failed lane beats over WIN delivered packets
// and decides the transmit mode with hysteresis.
// Assumes: EXIT_TH < ENTER_TH <= 4*WIN.
module slk_err_window #(
    parameter int WIN      = 8,
    parameter int ENTER_TH = 3,
    parameter int EXIT_TH  = 1,
    localparam int CW = $clog2(4 * WIN + 1),
    localparam int WW = $clog2(WIN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lane_bad,
    input  logic       pkt_done,
    output logic       dup_req
);
    logic [CW-1:0] ecnt;
    logic [CW-1:0] tot;
    logic [WW-1:0] wcnt;

    assign tot = ecnt + CW'(lane_bad[0]) + CW'(lane_bad[1]);

    // Accumulate failures and judge the window on its last packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt    <= '0;
            wcnt    <= '0;
            dup_req <= 1'b0;
        end else if (pkt_done && (wcnt == WW'(WIN - 1))) begin
            ecnt <= '0;
            wcnt <= '0;
            if (tot >= CW'(ENTER_TH))     dup_req <= 1'b1;
            else if (tot <= CW'(EXIT_TH)) dup_req <= 1'b0;
        end else begin
            ecnt <= tot;
            if (pkt_done) wcnt <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/slice_link.sv
// Top: two-lane link transmitter and receiver with error-driven switching
// between split and duplicate transmission.
// Assumes: tx lanes reach rx lanes through an external path; the receiver's
// error verdict drives the local transmitter's mode.
module slice_link #(
    parameter int HALF_W   = 16,
    parameter int WIN      = 8,
    parameter int ENTER_TH = 3,
    parameter int EXIT_TH  = 1,
    localparam int FW = HALF_W + 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2*HALF_W-1:0] in_data,
    output logic                tx_lane_vld,
    output logic [FW-1:0]       tx_lane0,
    output logic [FW-1:0]       tx_lane1,
    input  logic                rx_lane_vld,
    input  logic [FW-1:0]       rx_lane0,
    input  logic [FW-1:0]       rx_lane1,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] out_data,
    output logic                out_err,
    output logic                dup_mode
);
    logic [1:0][FW-1:0] tx_lanes;
    logic [1:0]         lane_bad;
    logic               pkt_done;

    slk_tx #(.HALF_W(HALF_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .dup_req(dup_mode), .lane_vld(tx_lane_vld), .lanes(tx_lanes)
    );

    assign tx_lane0 = tx_lanes[0];
    assign tx_lane1 = tx_lanes[1];

    slk_rx #(.HALF_W(HALF_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .lane_vld(rx_lane_vld), .lanes({rx_lane1, rx_lane0}),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
        .lane_bad(lane_bad), .pkt_done(pkt_done)
    );

    slk_err_window #(.WIN(WIN), .ENTER_TH(ENTER_TH), .EXIT_TH(EXIT_TH)) i_win (
        .clk(clk), .rst_n(rst_n), .lane_bad(lane_bad), .pkt_done(pkt_done), .dup_req(dup_mode)
    );
endmodule

// File: rtl/slice_link_chk.sv
// Checker for slice_link transmit framing, mode timing and reset state.
// Assumes: header bits at FW-1 (mode) and FW-2 (part).
module slice_link_chk #(
    parameter int HALF_W = 16,
    localparam int FW = HALF_W + 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          tx_lane_vld,
    input logic [FW-1:0] tx_lane0,
    input logic [FW-1:0] tx_lane1,
    input logic          out_valid,
    input logic          dup_mode
);
    AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> tx_lane_vld); // R2
    AST_SPLIT_PARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lane_vld && !tx_lane0[FW-1] |-> !tx_lane0[FW-2] && tx_lane1[FW-2] && !tx_lane1[FW-1]); // R2
    AST_DUP_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lane_vld && tx_lane0[FW-1] |-> tx_lane0 == tx_lane1); // R3
    AST_DUP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lane_vld && tx_lane0[FW-1] && !tx_lane0[FW-2] |-> !in_ready); // R3
    AST_DUP_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lane_vld && tx_lane0[FW-1] && !tx_lane0[FW-2] |=> tx_lane_vld && tx_lane0[FW-1] && tx_lane0[FW-2]); // R7
    AST_MODE_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dup_mode) |-> out_valid); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid && !tx_lane_vld && !dup_mode && in_ready); // R8
endmodule

bind slice_link slice_link_chk #(.HALF_W(HALF_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .tx_lane_vld(tx_lane_vld), .tx_lane0(tx_lane0), .tx_lane1(tx_lane1),
    .out_valid(out_valid), .dup_mode(dup_mode)
);

// File: tb/test_slice_link.sv
// Bench: loops tx lanes back to rx lanes through a bit-flip injector and
// checks framing, delivery and the mode decisions against a bench model.
module test_slice_link;
    localparam int HALF_W = 16;
    localparam int PKW    = 2 * HALF_W;
    localparam int FW     = HALF_W + 10;
    localparam int WIN    = 8;
    localparam int ENT    = 3;
    localparam int EXT    = 1;
    localparam logic [FW-1:0] FLIP = FW'(1) << 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [PKW-1:0] in_data = '0;
    logic           tx_lane_vld;
    logic [FW-1:0]  tx_lane0, tx_lane1;
    logic [FW-1:0]  mask0 = '0, mask1 = '0;
    logic           out_valid, out_err, dup_mode;
    logic [PKW-1:0] out_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_w = 0, m_e = 0;
    logic m_dup = 1'b0;

    always #10 clk = ~clk;

    slice_link #(.HALF_W(HALF_W), .WIN(WIN), .ENTER_TH(ENT), .EXIT_TH(EXT)) i_slice_link (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .tx_lane_vld(tx_lane_vld), .tx_lane0(tx_lane0), .tx_lane1(tx_lane1),
        .rx_lane_vld(tx_lane_vld), .rx_lane0(tx_lane0 ^ mask0), .rx_lane1(tx_lane1 ^ mask1),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err), .dup_mode(dup_mode)
    );

    function automatic logic [7:0] ref_crc(input logic [HALF_W+1:0] w);
        logic [7:0] c = 8'h00;
        for (int i = HALF_W + 1; i >= 0; i--) begin
            logic fb = c[7] ^ w[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [FW-1:0] ref_beat(input logic m, input logic p, input logic [HALF_W-1:0] h);
        return {m, p, h, ref_crc({m, p, h})};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Window model for R6
    task automatic model_pkt(input int errs);
        m_e += errs;
        m_w++;
        if (m_w == WIN) begin
            if (m_e >= ENT)      m_dup = 1'b1;
            else if (m_e <= EXT) m_dup = 1'b0;
            m_w = 0;
            m_e = 0;
        end
    endtask

    // One packet; c0/c1 bit k corrupts beat k of lane 0/1
    task automatic send(input logic [PKW-1:0] d, input logic [1:0] c0, input logic [1:0] c1);
        logic md = m_dup;
        logic [HALF_W-1:0] lo = d[HALF_W-1:0];
        logic [HALF_W-1:0] hi = d[PKW-1:HALF_W];
        logic g0, g1, xerr;
        int errs;
        @(negedge clk);
        chk(in_ready == 1'b1, "R7 ready at packet boundary", 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tx_lane_vld == 1'b1, "R2 beat launched", 64'(tx_lane_vld), 64'd1);
        if (md) begin
            chk(tx_lane0 == ref_beat(1'b1, 1'b0, lo), "R1 R3 R7 dup lane0 beat0", 64'(tx_lane0), 64'(ref_beat(1'b1, 1'b0, lo)));
            chk(tx_lane1 == ref_beat(1'b1, 1'b0, lo), "R3 dup lane1 beat0", 64'(tx_lane1), 64'(ref_beat(1'b1, 1'b0, lo)));
            chk(in_ready == 1'b0, "R3 stall on first dup beat", 64'(in_ready), 64'd0);
        end else begin
            chk(tx_lane0 == ref_beat(1'b0, 1'b0, lo), "R1 R2 R7 split lane0", 64'(tx_lane0), 64'(ref_beat(1'b0, 1'b0, lo)));
            chk(tx_lane1 == ref_beat(1'b0, 1'b1, hi), "R1 R2 split lane1", 64'(tx_lane1), 64'(ref_beat(1'b0, 1'b1, hi)));
        end
        mask0 = c0[0] ? FLIP : '0;
        mask1 = c1[0] ? FLIP : '0;
        @(negedge clk);
        if (md) begin
            chk(tx_lane_vld && tx_lane0 == ref_beat(1'b1, 1'b1, hi), "R3 R7 dup lane0 beat1", 64'(tx_lane0), 64'(ref_beat(1'b1, 1'b1, hi)));
            chk(tx_lane1 == ref_beat(1'b1, 1'b1, hi), "R3 dup lane1 beat1", 64'(tx_lane1), 64'(ref_beat(1'b1, 1'b1, hi)));
            chk(out_valid == 1'b0, "R5 no delivery after first beat", 64'(out_valid), 64'd0);
            mask0 = c0[1] ? FLIP : '0;
            mask1 = c1[1] ? FLIP : '0;
            @(negedge clk);
        end
        mask0 = '0;
        mask1 = '0;
        chk(out_valid == 1'b1, "R4 R5 delivered", 64'(out_valid), 64'd1);
        if (md) begin
            g0 = !(c0[0] || c0[1]);
            g1 = !(c1[0] || c1[1]);
            xerr = !g0 && !g1;
            errs = int'(c0[0]) + int'(c0[1]) + int'(c1[0]) + int'(c1[1]);
            chk(out_err == xerr, "R5 dup error flag", 64'(out_err), 64'(xerr));
            if (!xerr) chk(out_data == d, "R5 surviving copy", 64'(out_data), 64'(d));
        end else begin
            xerr = c0[0] || c1[0];
            errs = int'(c0[0]) + int'(c1[0]);
            chk(out_err == xerr, "R4 split error flag", 64'(out_err), 64'(xerr));
            if (!xerr) chk(out_data == d, "R4 split reassembly", 64'(out_data), 64'(d));
        end
        model_pkt(errs);
        chk(dup_mode == m_dup, "R6 mode decision", 64'(dup_mode), 64'(m_dup));
    endtask

    // Three back-to-back clean split packets
    task automatic burst3(input logic [PKW-1:0] a, input logic [PKW-1:0] b, input logic [PKW-1:0] c);
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready burst 0", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_data = a;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready burst 1", 64'(in_ready), 64'd1);
        in_data = b;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready burst 2", 64'(in_ready), 64'd1);
        in_data = c;
        chk(out_valid && out_data == a, "R2 R4 burst out a", 64'(out_data), 64'(a));
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_data == b, "R2 R4 burst out b", 64'(out_data), 64'(b));
        @(negedge clk);
        chk(out_valid && out_data == c && !out_err, "R2 R4 burst out c", 64'(out_data), 64'(c));
        for (int i = 0; i < 3; i++) model_pkt(0);
        chk(dup_mode == m_dup, "R6 mode after burst", 64'(dup_mode), 64'(m_dup));
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dup_mode && !tx_lane_vld && !out_valid && in_ready, "R8 reset state",
            64'({dup_mode, tx_lane_vld, out_valid, in_ready}), 64'h1);

        // Window 1: two failures, between thresholds, mode holds
        send(32'h1234_5678, 2'b00, 2'b00);
        send(32'hCAFE_F00D, 2'b00, 2'b01);
        send(32'h0BAD_BEEF, 2'b01, 2'b00);
        burst3(32'h1111_2222, 32'h3333_4444, 32'h5555_6666);
        send(32'h0000_0000, 2'b00, 2'b00);
        send(32'hFFFF_FFFF, 2'b00, 2'b00);
        send(32'hA5A5_5A5A, 2'b00, 2'b00);
        chk(dup_mode == 1'b0, "R6 hysteresis hold split", 64'(dup_mode), 64'd0);

        // Window 2: three failures, enter duplicate mode
        send(32'h0101_0101, 2'b01, 2'b00);
        send(32'h0202_0202, 2'b01, 2'b00);
        send(32'h0303_0303, 2'b00, 2'b01);
        for (int i = 0; i < 5; i++) send(32'h1000_0000 + 32'(i), 2'b00, 2'b00);
        chk(dup_mode == 1'b1, "R6 enter duplicate", 64'(dup_mode), 64'd1);

        // Window 3: duplicate recoveries; four failures keep duplicate
        send(32'hDEAD_0001, 2'b10, 2'b00);
        send(32'hDEAD_0002, 2'b00, 2'b01);
        send(32'hDEAD_0003, 2'b01, 2'b10);
        for (int i = 0; i < 5; i++) send(32'h2000_0000 + 32'(i), 2'b00, 2'b00);
        chk(dup_mode == 1'b1, "R6 stay duplicate", 64'(dup_mode), 64'd1);

        // Window 4: clean, back to split
        for (int i = 0; i < 8; i++) send(32'h3000_0000 + 32'(i), 2'b00, 2'b00);
        chk(dup_mode == 1'b0, "R6 exit to split", 64'(dup_mode), 64'd0);

        // Random phase
        for (int i = 0; i < 120; i++) begin
            logic [1:0] c0 = 2'b00, c1 = 2'b00;
            if ($urandom % 8 >= 5) begin
                c0 = 2'($urandom);
                c1 = 2'($urandom);
                if (m_dup && c0[0] && c1[0]) c1[0] = 1'b0;
            end
            send($urandom, c0, c1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule